// File: doc/BRIEF.md
# Boot Chip-Select Generator

This block drives an active-low select for the external memory that holds the first code a processor runs. It watches a 24-bit address bus with a 16-bit data path and an asynchronous handshake: address, function-code space, read/write, address strobe and the two data strobes (upper and lower lane). When an access falls inside the programmed window and passes the space, direction and byte-lane qualifiers, the select goes low. After a programmed number of wait states the block returns an internal transfer acknowledge together with a port-width flag.

The block needs no software setup. Its base, option and pin-function registers reset to values that select the first 1 Mbyte starting at address zero, for reads and writes, in both privilege spaces, with 13 wait states. While reset is held, data line 0 is sampled to decide whether the boot memory is 8 or 16 bits wide. That width stays fixed until the next reset. Software may later reprogram the window, the qualifiers and the timing through a small write port.

Top module: `boot_select`

## Requirements
- R1: After reset the base field is zero and an access to address 0x000000 in supervisor or user space with address strobe and a data strobe low drives `sel_n` low at the first clock edge.
- R2: After reset the block size is 1 Mbyte: every address from 0x000000 to 0x0FFFFF is selected and no address at or above 0x100000 is.
- R3: `d0_in` is sampled on each clock while `rst_n` is low. The last sampled value sets the port width (`ack_wide`=1 for 16 bits when high, 0 for 8 bits when low) and holds until the next reset, whatever later happens on `d0_in` or the register port. `ack_wide` is never high without `ack`.
- R4: The pin-function bit (write port `reg_sel`=2, `reg_wdata[1]`) resets to 1 (chip-select). Writing 0 turns the pin into general I/O, and `sel_n` then stays high for every access.
- R5: The byte qualifier resets to both lanes and the direction qualifier to both. In the option word (`reg_sel`=1), bit 14 enables the upper lane (`uds_n`), bit 13 the lower lane (`lds_n`), bit 12 reads (`rw`=1) and bit 11 writes. An access matching no enabled lane or direction is not selected.
- R6: Option bits 9:6 hold the wait count, 13 after reset. `ack` rises exactly that many clocks after `sel_n` falls (in the same cycle when the count is 0). Counts 14 and 15 give no internal `ack`.
- R7: Option bits 5:4 choose the space: 11 both (reset), 10 supervisor (`fc` 5,6), 01 user (`fc` 1,2), 00 CPU space. Outside CPU-space mode `fc`=7 is never selected. In CPU-space mode the select needs `fc`=7, `addr[19:16]`=0xF and a level match, and the base is not compared.
- R8: Option bits 3:1 (level; 0 means any) and bit 0 (autovector, which blocks the select) act only in CPU-space mode. A level compares with `addr[3:1]`. Otherwise they have no effect.
- R9: `sel_n` is high out of reset and is low only if a strobe was active at the previous edge. It returns high at the first edge at which all strobes are negated.
- R10: Word `reg_sel`=0 holds the base in bits 15:3 (compared with `addr[23:11]`) and a size code in bits 2:0: 0=2K, 1=8K, 2=16K, 3=64K, 4=128K, 5=256K, 6=512K, 7=1M (reset). A written window replaces the reset window.
- R11: Option bit 15 picks the handshake: 0 (reset) holds `ack` until the strobe ends, 1 gives a one-cycle `ack` pulse.
- R12: Option bit 10 picks the strobe: 0 (reset) follows `as_n`, 1 follows the data strobes, so `as_n` alone then selects nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| addr | input | 24 | Bus address |
| fc | input | 3 | Function-code space |
| rw | input | 1 | 1 read, 0 write |
| as_n | input | 1 | Address strobe, active low |
| uds_n | input | 1 | Upper data strobe, active low |
| lds_n | input | 1 | Lower data strobe, active low |
| d0_in | input | 1 | Data line 0, sampled during reset |
| reg_we | input | 1 | Register write enable |
| reg_sel | input | 2 | 0 base, 1 option, 2 pin function |
| reg_wdata | input | 16 | Register write data |
| sel_n | output | 1 | Boot chip-select, active low |
| ack | output | 1 | Internal transfer acknowledge |
| ack_wide | output | 1 | 1 = 16-bit port, valid with ack |

## Verification
The bench looks for the edges of the 1 Mbyte window: the last selected byte and the first one after it. A mask built from the wrong size code would select above 0x0FFFFF or miss the top of the window. It counts the thirteen-wait acknowledge to the cycle, where a counter that starts one cycle late or compares off by one acknowledges early or late. It also resets once with data line 0 high and once with it low, then moves that line and writes the pin register, so a width taken after reset would report the wrong port size. Finally it puts level and autovector values into a configuration that is not CPU space, where a design that decodes them anyway would drop a valid select.

// File: rtl/boot_select.sv
module boot_select #(
  parameter int AW = 24,
  parameter int RW = 16,
  parameter logic [RW-1:0] BASE_RST = 16'h0007,
  parameter logic [RW-1:0] OPT_RST  = 16'h7B70
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic [2:0]    fc,
  input  logic          rw,
  input  logic          as_n,
  input  logic          uds_n,
  input  logic          lds_n,
  input  logic          d0_in,
  input  logic          reg_we,
  input  logic [1:0]    reg_sel,
  input  logic [RW-1:0] reg_wdata,
  output logic          sel_n,
  output logic          ack,
  output logic          ack_wide
);
  localparam int BW = AW - 11;

  logic [RW-1:0] base_q, opt_q;
  logic          pin_cs_q, wide_q, sel_q;
  logic [3:0]    cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q   <= BASE_RST;
      opt_q    <= OPT_RST;
      pin_cs_q <= 1'b1;
      wide_q   <= d0_in;
    end else if (reg_we) begin
      case (reg_sel)
        2'd0:    base_q   <= reg_wdata;
        2'd1:    opt_q    <= reg_wdata;
        2'd2:    pin_cs_q <= reg_wdata[1];
        default: ;
      endcase
    end
  end

  function automatic int ignored_bits(input logic [2:0] code);
    case (code)
      3'd0:    return 0;
      3'd1:    return 2;
      3'd2:    return 3;
      3'd3:    return 5;
      3'd4:    return 6;
      3'd5:    return 7;
      3'd6:    return 8;
      default: return 9;
    endcase
  endfunction

  logic [BW-1:0] mask;
  logic          addr_hit, strobe_on, lane_ok, dir_ok, space_ok, cpu_mode, cpu_hit, hit;
  logic [3:0]    waits;
  logic          sync_mode;

  assign mask      = {BW{1'b1}} << ignored_bits(base_q[2:0]);
  assign addr_hit  = ((addr[AW-1:11] ^ base_q[RW-1:RW-BW]) & mask) == '0;
  assign strobe_on = opt_q[10] ? (!uds_n || !lds_n) : !as_n;
  assign lane_ok   = (opt_q[14] && !uds_n) || (opt_q[13] && !lds_n);
  assign dir_ok    = rw ? opt_q[12] : opt_q[11];
  assign space_ok  = ((fc == 3'd1 || fc == 3'd2) && opt_q[4]) ||
                     ((fc == 3'd5 || fc == 3'd6) && opt_q[5]);
  assign cpu_mode  = opt_q[5:4] == 2'b00;
  assign cpu_hit   = fc == 3'd7 && addr[19:16] == 4'hF && !opt_q[0] &&
                     (opt_q[3:1] == 3'd0 || opt_q[3:1] == addr[3:1]);
  assign hit       = pin_cs_q && strobe_on &&
                     (cpu_mode ? cpu_hit : (space_ok && addr_hit && dir_ok && lane_ok));
  assign waits     = opt_q[9:6];
  assign sync_mode = opt_q[15];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      sel_q <= hit;
      if (!sel_q)
        cnt_q <= '0;
      else if (cnt_q != 4'hF && !(!sync_mode && cnt_q == waits))
        cnt_q <= cnt_q + 4'd1;
    end
  end

  assign sel_n    = !sel_q;
  assign ack      = sel_q && waits <= 4'd13 && cnt_q == waits;
  assign ack_wide = ack && wide_q;

  assert_sel_needs_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_n |-> $past(!as_n || !uds_n || !lds_n));
  assert_sel_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (as_n && uds_n && lds_n) |=> sel_n);
  assert_ack_in_select_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> !sel_n);
  assert_wide_with_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ack_wide |-> ack);
  assert_width_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(wide_q));
  assert_pin_off_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !pin_cs_q |=> sel_n);
  assert_sync_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_mode && ack && !reg_we) |=> !ack);
endmodule

// File: tb/boot_select_tb_top.sv
module boot_select_tb_top;
  localparam int CLK_P = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [23:0] addr = '0;
  logic [2:0]  fc = 3'd6;
  logic        rw = 1'b1, as_n = 1'b1, uds_n = 1'b1, lds_n = 1'b1, d0_in = 1'b1;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_sel = '0;
  logic [15:0] reg_wdata = '0;
  logic        sel_n, ack, ack_wide;
  int          errors = 0, checks = 0;

  always #(CLK_P/2) clk = ~clk;

  boot_select dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .fc(fc), .rw(rw), .as_n(as_n),
    .uds_n(uds_n), .lds_n(lds_n), .d0_in(d0_in), .reg_we(reg_we),
    .reg_sel(reg_sel), .reg_wdata(reg_wdata), .sel_n(sel_n), .ack(ack),
    .ack_wide(ack_wide));

  // [31:8] address, [7:5] fc, [4] rw, [0] select expected (default config)
  localparam logic [31:0] VEC [8] = '{
    32'h000000D1, 32'h0FFFFFA1, 32'h100000D0, 32'hFFFFFE50,
    32'h08000031, 32'h07FF0041, 32'h000000F0, 32'h200000A0 };

  localparam logic [15:0] OPT_DEF = 16'h7B70;

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic d0);
    @(negedge clk);
    rst_n = 1'b0; d0_in = d0; as_n = 1'b1; uds_n = 1'b1; lds_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [1:0] s, input logic [15:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = s; reg_wdata = d;
    @(posedge clk); #1;
    reg_we = 1'b0;
  endtask

  task automatic access(input logic [23:0] a, input logic [2:0] f, input logic r,
                        input logic a_n, input logic u_n, input logic l_n);
    @(negedge clk);
    addr = a; fc = f; rw = r; as_n = a_n; uds_n = u_n; lds_n = l_n;
    @(posedge clk); #1;
  endtask

  task automatic idle();
    @(negedge clk);
    as_n = 1'b1; uds_n = 1'b1; lds_n = 1'b1;
    @(posedge clk); #1;
  endtask

  initial begin
    #(CLK_P * 100000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    do_reset(1'b1);
    check("R9 reset sel_n", sel_n, 1);
    check("R6 reset ack", ack, 0);

    foreach (VEC[i]) begin
      access(VEC[i][31:8], VEC[i][7:5], VEC[i][4], 1'b0, 1'b0, 1'b0);
      check($sformatf("R2 vector %0d select", i), !sel_n, VEC[i][0]);
      idle();
      check($sformatf("R9 vector %0d release", i), sel_n, 1);
    end

    // R1 and R6: first fetch, 13 waits, 16-bit port
    access(24'h000000, 3'd6, 1'b1, 1'b0, 1'b0, 1'b0);
    check("R1 first fetch selected", sel_n, 0);
    begin
      int early = 0;
      for (int k = 0; k < 12; k++) begin
        if (ack) early++;
        @(posedge clk); #1;
      end
      check("R6 no ack before 13 waits", early + ack, 0);
    end
    @(posedge clk); #1;
    check("R6 ack at 13 waits", ack, 1);
    check("R3 wide port with d0 high", ack_wide, 1);
    @(posedge clk); #1;
    check("R11 async ack held", ack, 1);
    idle();
    check("R9 release after strobe", sel_n, 1);
    check("R11 ack drops with strobe", ack, 0);

    // R3: narrow port, held after reset
    do_reset(1'b0);
    @(negedge clk); d0_in = 1'b1;
    wr(2'd2, 16'h0003);
    access(24'h000000, 3'd6, 1'b1, 1'b0, 1'b0, 1'b0);
    repeat (13) begin @(posedge clk); #1; end
    check("R3 ack with narrow port", ack, 1);
    check("R3 narrow width held", ack_wide, 0);
    idle();

    // R4: pin function
    do_reset(1'b1);
    wr(2'd2, 16'h0000);
    access(24'h000000, 3'd6, 1'b1, 1'b0, 1'b0, 1'b0);
    check("R4 general I/O no select", sel_n, 1);
    idle();
    wr(2'd2, 16'h0002);
    access(24'h000000, 3'd6, 1'b1, 1'b0, 1'b0, 1'b0);
    check("R4 chip-select restored", sel_n, 0);
    idle();

    // R10: 2K window at 0x400000
    wr(2'd0, 16'h4000);
    access(24'h400000, 3'd5, 1'b1, 1'b0, 1'b0, 1'b0);
    check("R10 new base selected", sel_n, 0);
    idle();
    access(24'h400800, 3'd5, 1'b1, 1'b0, 1'b0, 1'b0);
    check("R10 beyond 2K not selected", sel_n, 1);
    idle();
    access(24'h000000, 3'd5, 1'b1, 1'b0, 1'b0, 1'b0);
    check("R10 old window gone", sel_n, 1);
    idle();

    // R5: upper lane, read only
    do_reset(1'b1);
    wr(2'd1, 16'h5370);
    access(24'h000010, 3'd6, 1'b1, 1'b0, 1'b0, 1'b1);
    check("R5 upper read selected", sel_n, 0);
    idle();
    access(24'h000010, 3'd6, 1'b1, 1'b0, 1'b1, 1'b0);
    check("R5 lower lane rejected", sel_n, 1);
    idle();
    access(24'h000010, 3'd6, 1'b0, 1'b0, 1'b0, 1'b0);
    check("R5 write rejected", sel_n, 1);
    idle();

    // R7: supervisor only
    wr(2'd1, OPT_DEF & ~16'h0010);
    access(24'h000010, 3'd2, 1'b1, 1'b0, 1'b0, 1'b0);
    check("R7 user rejected in supervisor mode", sel_n, 1);
    idle();
    access(24'h000010, 3'd6, 1'b1, 1'b0, 1'b0, 1'b0);
    check("R7 supervisor accepted", sel_n, 0);
    idle();

    // R8: level/autovector ignored outside CPU space
    wr(2'd1, 16'h7B77);
    access(24'h000000, 3'd6, 1'b1, 1'b0, 1'b0, 1'b0);
    check("R8 fields ignored outside CPU space", sel_n, 0);
    idle();

    // R7/R8: CPU space, level 3
    wr(2'd1, 16'h7B46);
    access(24'h0F0006, 3'd7, 1'b1, 1'b0, 1'b0, 1'b0);
    check("R7 CPU space level match", sel_n, 0);
    idle();
    access(24'h0F0004, 3'd7, 1'b1, 1'b0, 1'b0, 1'b0);
    check("R8 CPU space level mismatch", sel_n, 1);
    idle();
    access(24'h000000, 3'd6, 1'b1, 1'b0, 1'b0, 1'b0);
    check("R7 normal space in CPU mode", sel_n, 1);
    idle();
    wr(2'd1, 16'h7B47);
    access(24'h0F0006, 3'd7, 1'b1, 1'b0, 1'b0, 1'b0);
    check("R8 autovector blocks select", sel_n, 1);
    idle();

    // R11 and R6: sync, 2 waits
    wr(2'd1, 16'hF8B0);
    access(24'h000000, 3'd6, 1'b1, 1'b0, 1'b0, 1'b0);
    check("R6 no ack at wait 0 of 2", ack, 0);
    @(posedge clk); #1;
    @(posedge clk); #1;
    check("R6 ack after 2 waits", ack, 1);
    @(posedge clk); #1;
    check("R11 sync ack one cycle", ack, 0);
    idle();

    // R6: zero waits, async
    wr(2'd1, 16'h7830);
    access(24'h000000, 3'd6, 1'b1, 1'b0, 1'b0, 1'b0);
    check("R6 zero-wait ack", ack, 1);
    idle();

    // R6: 15 waits gives no ack
    wr(2'd1, 16'h7BF0);
    access(24'h000000, 3'd6, 1'b1, 1'b0, 1'b0, 1'b0);
    begin
      int seen = 0;
      for (int k = 0; k < 20; k++) begin
        if (ack) seen++;
        @(posedge clk); #1;
      end
      check("R6 no internal ack at 15", seen, 0);
    end
    idle();

    // R12: data-strobe timing
    wr(2'd1, 16'h7F70);
    access(24'h000000, 3'd6, 1'b1, 1'b0, 1'b1, 1'b1);
    check("R12 address strobe alone ignored", sel_n, 1);
    access(24'h000000, 3'd6, 1'b1, 1'b0, 1'b1, 1'b0);
    check("R12 data strobe selects", sel_n, 0);
    idle();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule